// File: doc/BRIEF.md
# Debounced GPIO Pin Controller

This block controls one general-purpose I/O pin. A small register file, reached through a byte-addressed write strobe and a combinational read port, sets the pin up. It sets the pin enable, the drive direction, whether the output driver floats, the output level, the debounce threshold and the interrupt trigger. The pad input passes through a two-flop synchroniser. An optional filter follows it and accepts a new level only once that level has held for a programmed number of millisecond ticks. The millisecond tick comes in as a single-cycle pulse from a shared time base.

Interrupt detection looks at the filtered level. A 2-bit trigger mode selects off, level, single edge or both edges. A separate polarity bit chooses high level or rising edge when set, and low level or falling edge when clear. A level trigger is pending only while the active level is present. An edge trigger latches and stays pending until software writes a clear. An interrupt-enable bit gates the request without disturbing anything that is pending.

Top module: `gpio_pin_unit`

## Requirements
- R1: After reset every register reads 0, `padOe` is 0 and `irqReq` is 0.
- R2: The registers are at these byte addresses:
  - 0x00 config, 7 bits: bit0 pin enable, bit1 drive out, bits[3:2] trigger mode, bit4 polarity, bit5 debounce enable, bit6 interrupt enable.
  - 0x04 debounce threshold, 8 bits.
  - 0x08 input level in bit0, read-only.
  - 0x0C float in bit0.
  - 0x10 output level in bit0.
  - 0x14 interrupt clear, which reads 0.
  
  Writable registers read back what was written.
- R3: With debounce off, a pad change appears at the input register bit0 after the third rising clock edge that follows it, and not after the second.
- R4: `padOe` is 1 exactly when pin enable is 1, drive out is 1 and float is 0. `padOut` follows output-level bit0.
- R5: With debounce on and threshold N, a differing synchronised level is accepted on the clock edge after N ticks have been seen while it differed. A level that returns before that point is discarded, and the tick count restarts.
- R6: Trigger mode 1 (level) makes the interrupt pending while the filtered level equals the polarity bit (1 = high, 0 = low), and not pending otherwise.
- R7: Trigger mode 2 (single edge) latches a pending interrupt on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge is ignored.
- R8: Trigger mode 3 (both edges) latches on either edge whatever the polarity. A latched edge stays pending until cleared.
- R9: Writing a value with bit0 = 1 to 0x14 clears a latched edge, and writing 0 there has no effect. An edge detected in the same cycle as the clear write stays pending.
- R10: With interrupt enable 0, `irqReq` is 0 but a latched edge is kept. Setting the enable again raises `irqReq`.
- R11: Trigger mode 0, or pin enable 0, records no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational on regAddr |
| padIn | input | 1 | Asynchronous pad input |
| padOut | output | 1 | Pad output level |
| padOe | output | 1 | Pad output-driver enable |
| irqReq | output | 1 | Interrupt request |

## Verification
Two functions can act on the edge latch in the same cycle: a new edge setting it and a software clear write. In both-edge mode, the bench toggles the pad on a falling clock edge. It then waits exactly three rising edges, the point at which the filtered level is visible and not yet recorded as the previous level. It times the clear write so that the write's rising edge is the one on which the edge is latched. The request must still be high afterwards, because a set wins over a clear. A clear issued one cycle apart from any edge must drop the request.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF       = 2'd0,
    TRIG_LEVEL     = 2'd1,
    TRIG_ONE_EDGE  = 2'd2,
    TRIG_BOTH_EDGE = 2'd3
  } trigMode_e;

  // packed MSB first: bit6 .. bit0
  typedef struct packed {
    logic      intEn;
    logic      debEn;
    logic      polHigh;
    trigMode_e mode;
    logic      dirOut;
    logic      pinEn;
  } pinCfg_t;

  localparam int CFG_W = $bits(pinCfg_t);

  typedef struct packed {
    logic clrPend;    // drop latched edge
    logic restartDeb; // restart debounce count
  } ctrlStrobe_t;

  localparam int OFS_CFG = 'h00;
  localparam int OFS_DEB = 'h04;
  localparam int OFS_IN  = 'h08;
  localparam int OFS_FLT = 'h0C;
  localparam int OFS_OUT = 'h10;
  localparam int OFS_CLR = 'h14;

endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              inLvl,
  output pinCfg_t           cfg,
  output logic [DEB_W-1:0]  debThr,
  output logic              floatQ,
  output logic              outQ,
  output ctrlStrobe_t       strb
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_DEB = ADDR_W'(OFS_DEB);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_FLT = ADDR_W'(OFS_FLT);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      debThr <= '0;
      floatQ <= 1'b0;
      outQ   <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        A_CFG:   cfg    <= pinCfg_t'(regWdata[CFG_W-1:0]);
        A_DEB:   debThr <= regWdata[DEB_W-1:0];
        A_FLT:   floatQ <= regWdata[0];
        A_OUT:   outQ   <= regWdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clrPend    = regWe && (regAddr == A_CLR) && regWdata[0];
    strb.restartDeb = regWe && (regAddr == A_DEB);
  end

  always_comb begin
    case (regAddr)
      A_CFG:   regRdata = DATA_W'(cfg);
      A_DEB:   regRdata = DATA_W'(debThr);
      A_IN:    regRdata = DATA_W'(inLvl);
      A_FLT:   regRdata = DATA_W'(floatQ);
      A_OUT:   regRdata = DATA_W'(outQ);
      default: regRdata = '0;
    endcase
  end

  // R2: an output-level write lands the following cycle
  assert_out_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_OUT) |=> (outQ == $past(regWdata[0])));

endmodule

// File: rtl/gpio_pin_datapath.sv
module gpio_pin_datapath
  import gpio_pin_pkg::*;
#(
  parameter int DEB_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             padIn,
  input  pinCfg_t          cfg,
  input  logic [DEB_W-1:0] debThr,
  input  logic             floatQ,
  input  logic             outQ,
  input  ctrlStrobe_t      strb,
  output logic             inLvl,
  output logic             padOut,
  output logic             padOe,
  output logic             irqReq
);

  logic             syncA, syncB;
  logic             filtLvl, prevLvl;
  logic [DEB_W-1:0] dbCnt;
  logic             edgeHit, levelHit, edgeLatch;
  logic             riseEv, fallEv;

  // synchroniser and debounce filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      filtLvl <= 1'b0;
      prevLvl <= 1'b0;
      dbCnt   <= '0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      prevLvl <= filtLvl;
      if (!cfg.debEn) begin
        filtLvl <= syncB;
        dbCnt   <= '0;
      end else if (syncB == filtLvl || strb.restartDeb) begin
        dbCnt <= '0;
      end else if (dbCnt >= debThr) begin
        filtLvl <= syncB;
        dbCnt   <= '0;
      end else if (msTick) begin
        dbCnt <= dbCnt + 1'b1;
      end
    end
  end

  assign riseEv = filtLvl & ~prevLvl;
  assign fallEv = ~filtLvl & prevLvl;

  always_comb begin
    case (cfg.mode)
      TRIG_ONE_EDGE:  edgeHit = cfg.polHigh ? riseEv : fallEv;
      TRIG_BOTH_EDGE: edgeHit = riseEv | fallEv;
      default:        edgeHit = 1'b0;
    endcase
    edgeHit  = edgeHit & cfg.pinEn;
    levelHit = cfg.pinEn && (cfg.mode == TRIG_LEVEL) && (filtLvl == cfg.polHigh);
  end

  // edge latch: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)              edgeLatch <= 1'b0;
    else if (edgeHit)       edgeLatch <= 1'b1;
    else if (strb.clrPend)  edgeLatch <= 1'b0;
  end

  assign inLvl  = filtLvl;
  assign irqReq = (levelHit | edgeLatch) & cfg.intEn;
  assign padOe  = cfg.pinEn & cfg.dirOut & ~floatQ;
  assign padOut = outQ;

  // R3: without filtering the accepted level is the synchroniser output one cycle on
  assert_sync_path_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfg.debEn) |-> (filtLvl == $past(syncB)));

  // R5: a filtered change under debounce only after the count reached the threshold
  assert_debounce_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLvl) |-> (!$past(cfg.debEn) || ($past(dbCnt) >= $past(debThr))));

  // R8: latched edge persists without a clear
  assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (edgeLatch && !strb.clrPend) |=> edgeLatch);

  // R9: a clear with no concurrent edge empties the latch
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPend && !edgeHit) |=> !edgeLatch);

endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
  import gpio_pin_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic              irqReq
);

  pinCfg_t          cfgBus;
  logic [DEB_W-1:0] thrBus;
  logic             floatBus, outBus, inLvlBus;
  ctrlStrobe_t      strbBus;

  gpio_pin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEB_W(DEB_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inLvl(inLvlBus),
    .cfg(cfgBus), .debThr(thrBus), .floatQ(floatBus), .outQ(outBus),
    .strb(strbBus)
  );

  gpio_pin_datapath #(.DEB_W(DEB_W)) uPath (
    .clk(clk), .rstN(rstN), .msTick(msTick), .padIn(padIn),
    .cfg(cfgBus), .debThr(thrBus), .floatQ(floatBus), .outQ(outBus),
    .strb(strbBus), .inLvl(inLvlBus), .padOut(padOut), .padOe(padOe),
    .irqReq(irqReq)
  );

endmodule

// File: tb/gpio_pin_unit_test.sv
module gpio_pin_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       padIn = 1'b0;
  logic       padOut, padOe, irqReq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_pin_unit uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqReq(irqReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input int exp);
    regAddr = a;
    #2;
    chk(req, int'(regRdata), exp);
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); msTick = 1'b1;
    @(negedge clk); msTick = 1'b0;
  endtask

  task automatic setPad(input logic v);
    @(negedge clk); padIn = v;
    waitClk(5);
  endtask

  task automatic testReset();
    rdChk("R1 cfg", 5'h00, 0);
    rdChk("R1 thr", 5'h04, 0);
    rdChk("R1 in", 5'h08, 0);
    rdChk("R1 float", 5'h0C, 0);
    rdChk("R1 out", 5'h10, 0);
    chk("R1 padOe", padOe, 0);
    chk("R1 irqReq", irqReq, 0);
  endtask

  task automatic testRegs();
    wr(5'h00, 8'h7F); rdChk("R2 cfg", 5'h00, 'h7F);
    wr(5'h04, 8'hA5); rdChk("R2 thr", 5'h04, 'hA5);
    wr(5'h0C, 8'h01); rdChk("R2 float", 5'h0C, 1);
    wr(5'h10, 8'h01); rdChk("R2 out", 5'h10, 1);
    rdChk("R2 clr reads 0", 5'h14, 0);
    wr(5'h00, 8'h00);
  endtask

  task automatic testPadDrive();
    wr(5'h00, 8'h03); wr(5'h0C, 8'h00); wr(5'h10, 8'h01);
    #2; chk("R4 oe on", padOe, 1); chk("R4 out high", padOut, 1);
    wr(5'h10, 8'h00); #2; chk("R4 out low", padOut, 0);
    wr(5'h0C, 8'h01); #2; chk("R4 floated", padOe, 0);
    wr(5'h0C, 8'h00); wr(5'h00, 8'h01); #2; chk("R4 input dir", padOe, 0);
    wr(5'h00, 8'h02); #2; chk("R4 pin off", padOe, 0);
    wr(5'h00, 8'h00);
  endtask

  task automatic testSync();
    @(negedge clk); padIn = 1'b1;
    @(posedge clk); @(posedge clk);
    rdChk("R3 not after 2 edges", 5'h08, 0);
    @(posedge clk);
    rdChk("R3 after 3 edges", 5'h08, 1);
    setPad(1'b0);
  endtask

  task automatic testDebounce();
    wr(5'h04, 8'd3); wr(5'h00, 8'h21);
    @(negedge clk); padIn = 1'b1; waitClk(4);
    tick(); tick();
    rdChk("R5 held after 2 ticks", 5'h08, 0);
    tick();
    rdChk("R5 held until next edge", 5'h08, 0);
    waitClk(1);
    rdChk("R5 accepted", 5'h08, 1);
    @(negedge clk); padIn = 1'b0; waitClk(4);
    tick(); tick();
    @(negedge clk); padIn = 1'b1; waitClk(4);
    tick(); tick(); tick(); tick();
    rdChk("R5 glitch discarded", 5'h08, 1);
    wr(5'h00, 8'h00);
    setPad(1'b0);
  endtask

  task automatic testLevel();
    wr(5'h00, 8'h55); #2;
    chk("R6 high pol, pad low", irqReq, 0);
    setPad(1'b1); chk("R6 high pol, pad high", irqReq, 1);
    setPad(1'b0); chk("R6 level gone", irqReq, 0);
    wr(5'h00, 8'h45); #2;
    chk("R6 low pol, pad low", irqReq, 1);
    wr(5'h00, 8'h00);
  endtask

  task automatic testSingleEdge();
    wr(5'h00, 8'h59); wr(5'h14, 8'h01);
    setPad(1'b1); chk("R7 rising latched", irqReq, 1);
    waitClk(5); chk("R8 latch sticky", irqReq, 1);
    wr(5'h14, 8'h01); #2; chk("R9 cleared", irqReq, 0);
    setPad(1'b0); chk("R7 falling ignored", irqReq, 0);
    wr(5'h00, 8'h49);
    setPad(1'b1); chk("R7 rising ignored on low pol", irqReq, 0);
    setPad(1'b0); chk("R7 falling latched", irqReq, 1);
    wr(5'h14, 8'h01);
  endtask

  task automatic testBothEdge();
    wr(5'h00, 8'h4D); wr(5'h14, 8'h01);
    setPad(1'b1); chk("R8 rise", irqReq, 1);
    wr(5'h14, 8'h01); #2; chk("R9 clear", irqReq, 0);
    setPad(1'b0); chk("R8 fall", irqReq, 1);
    wr(5'h14, 8'h00); #2; chk("R9 zero write ignored", irqReq, 1);
    wr(5'h14, 8'h01);
    wr(5'h00, 8'h5D);
    setPad(1'b1); chk("R8 polarity ignored", irqReq, 1);
    wr(5'h14, 8'h01);
    // coincidence: edge latched on the same edge as the clear write
    @(negedge clk); padIn = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    wr(5'h14, 8'h01); #2;
    chk("R9 edge beats clear", irqReq, 1);
    wr(5'h14, 8'h01); #2;
    chk("R9 later clear", irqReq, 0);
  endtask

  task automatic testMask();
    wr(5'h00, 8'h4D);
    setPad(1'b1); chk("R10 pending", irqReq, 1);
    wr(5'h00, 8'h0D); #2; chk("R10 masked", irqReq, 0);
    wr(5'h00, 8'h4D); #2; chk("R10 kept on unmask", irqReq, 1);
    wr(5'h14, 8'h01);
    setPad(1'b0);
    wr(5'h14, 8'h01);
  endtask

  task automatic testNoEvents();
    wr(5'h00, 8'h41);
    setPad(1'b1); setPad(1'b0);
    chk("R11 mode off", irqReq, 0);
    wr(5'h00, 8'h4D); #2; chk("R11 nothing recorded in mode off", irqReq, 0);
    wr(5'h00, 8'h4C);
    setPad(1'b1); setPad(1'b0);
    wr(5'h00, 8'h4D); #2; chk("R11 nothing recorded while disabled", irqReq, 0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    testReset();
    testRegs();
    testPadDrive();
    testSync();
    testDebounce();
    testLevel();
    testSingleEdge();
    testBothEdge();
    testMask();
    testNoEvents();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule